// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Programmable Dead Time

This block sits between a PWM source and the two gate-enable lines of one half-bridge leg. It takes a high-side command, which is active high, and a low-side command, which is active low. Because of that polarity pair, a single wire tied to both commands selects the conducting switch on its own: high picks the upper switch and low picks the lower one.

The block decodes the command pair and resolves any request for both switches to both off. It also enforces a programmable gap, counted in clock cycles, between one gate going low and the other gate going high. A shutdown enable and a supply-undervoltage flag both override the commands and force the leg into its tri-stated (both off) state.

All outputs are registered. A command that is sampled at one rising clock edge shows at the outputs right after that edge.

Top module: `halfbridge_guard`

## Requirements
- R1: While `enable` is 0, both gate outputs are driven to 0 from the edge that samples it, whatever the commands are. When `enable` returns to 1 after a low period at least as long as the dead time, the commanded gate turns on at the first edge.
- R2: The command pair `hiCmd`=0, `loCmdN`=0 turns on only `loGate`.
- R3: The command pair `hiCmd`=1, `loCmdN`=1 turns on only `hiGate`.
- R4: The command pair `hiCmd`=1, `loCmdN`=0 asks for both switches. It drives both gates to 0.
- R5: The command pair `hiCmd`=0, `loCmdN`=1 drives both gates to 0.
- R6: `hiGate` and `loGate` are never 1 in the same cycle.
- R7: When one gate turns off and the other is requested, both gates stay 0 for exactly D cycles before the requested gate turns on. D is `deadCycles`, or 1 when `deadCycles` is 0. The count is the same for high-to-low and low-to-high transitions.
- R8: If the commands leave both gates off for fewer than D cycles, the full D cycles of off time are still enforced. If both gates have already been off for at least D cycles, a new request turns its gate on at the first edge.
- R9: While `underVolt` is 1, both gates are 0. After it clears, both gates stay 0 for D cycles, counted from the first edge that samples it cleared, before any gate turns on.
- R10: Reset (`rstN`=0) drives both gates to 0 and marks the dead time as already expired. A valid command present at reset release turns its gate on at the first edge.
- R11: One signal tied to both `hiCmd` and `loCmdN` alternates the leg between `hiGate` and `loGate`, with D off cycles at each change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hiCmd | input | 1 | High-side command, active high |
| loCmdN | input | 1 | Low-side command, active low |
| enable | input | 1 | Shutdown enable; 0 forces both gates off |
| underVolt | input | 1 | Supply undervoltage flag; 1 forces both gates off |
| deadCycles | input | DT_W | Dead time in clock cycles (0 acts as 1) |
| hiGate | output | 1 | High-side gate enable |
| loGate | output | 1 | Low-side gate enable |

## Verification
The four command pairs are applied one at a time. This shows whether the decoder picks the right gate, refuses the double request, and leaves the leg tri-stated for the idle pair.

A tied single command is toggled in both directions with several dead-time values, including zero. This shows whether the off gap is counted correctly and matches in both directions.

Idle gaps shorter and longer than the dead time are also applied. They separate enforced waiting from direct following.

Shutdown and undervoltage pulses, plus a reset release with a command already present, show which overrides reload the gap and which leave it expired.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_HI   = 2'd1,
    REQ_LO   = 2'd2
  } gateReq_e;

  // Strobes from the control to the gate registers.
  typedef struct packed {
    logic clrAll;
    logic setHi;
    logic setLo;
  } gateStrobe_t;

endpackage

// File: rtl/hbg_cmd_decode.sv
module hbg_cmd_decode
  import hbg_pkg::*;
(
  input  logic     hiCmd,
  input  logic     loCmdN,
  input  logic     enable,
  input  logic     underVolt,
  output gateReq_e req
);

  always_comb begin
    req = REQ_NONE;
    if (enable && !underVolt) begin
      unique case ({hiCmd, loCmdN})
        2'b11:   req = REQ_HI;    // upper switch only
        2'b00:   req = REQ_LO;    // lower switch only
        default: req = REQ_NONE;  // conflict or idle: tri-state
      endcase
    end
  end

endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  gateReq_e        req,
  input  logic            underVolt,
  input  logic [DT_W-1:0] deadCycles,
  input  logic            hiGate,
  input  logic            loGate,
  output gateStrobe_t     strobe
);

  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  logic [DT_W-1:0] offCnt;
  logic [DT_W-1:0] dtEff;
  logic            bothLow;
  logic            gapDone;
  logic            bothLowNext;

  assign dtEff   = (deadCycles == '0) ? CNT_ONE : deadCycles;
  assign bothLow = !hiGate && !loGate;
  assign gapDone = bothLow && (offCnt >= dtEff);

  always_comb begin
    strobe = '0;
    unique case (req)
      REQ_HI: begin
        if (loGate)       strobe.clrAll = 1'b1;
        else if (gapDone) strobe.setHi  = 1'b1;
      end
      REQ_LO: begin
        if (hiGate)       strobe.clrAll = 1'b1;
        else if (gapDone) strobe.setLo  = 1'b1;
      end
      default: strobe.clrAll = 1'b1;
    endcase
  end

  assign bothLowNext = strobe.clrAll || (bothLow && !strobe.setHi && !strobe.setLo);

  // Counts the edges for which both gates have been low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= CNT_MAX;
    end else if (underVolt) begin
      offCnt <= '0;
    end else if (bothLowNext) begin
      if (!bothLow)             offCnt <= CNT_ONE;
      else if (offCnt != CNT_MAX) offCnt <= offCnt + CNT_ONE;
    end
  end

  // A turn-on strobe is only legal from the tri-stated state.
  assert_set_from_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setHi || strobe.setLo) |-> (!hiGate && !loGate));

  // Undervoltage restarts the gap from zero.
  assert_uv_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> (offCnt == '0));

endmodule

// File: rtl/hbg_gate_reg.sv
module hbg_gate_reg
  import hbg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        hiGate,
  output logic        loGate
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiGate <= 1'b0;
      loGate <= 1'b0;
    end else if (strobe.clrAll) begin
      hiGate <= 1'b0;
      loGate <= 1'b0;
    end else if (strobe.setHi) begin
      hiGate <= 1'b1;
      loGate <= 1'b0;
    end else if (strobe.setLo) begin
      hiGate <= 1'b0;
      loGate <= 1'b1;
    end
  end

  assert_never_both_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(hiGate && loGate));

  assert_no_direct_swap_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hiGate) |-> !$past(loGate)) and ($rose(loGate) |-> !$past(hiGate)));

endmodule

// File: rtl/halfbridge_guard.sv
module halfbridge_guard
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hiCmd,
  input  logic            loCmdN,
  input  logic            enable,
  input  logic            underVolt,
  input  logic [DT_W-1:0] deadCycles,
  output logic            hiGate,
  output logic            loGate
);

  gateReq_e    req;
  gateStrobe_t strobe;

  hbg_cmd_decode u_decode (
    .hiCmd     (hiCmd),
    .loCmdN    (loCmdN),
    .enable    (enable),
    .underVolt (underVolt),
    .req       (req)
  );

  hbg_ctrl #(.DT_W(DT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .req        (req),
    .underVolt  (underVolt),
    .deadCycles (deadCycles),
    .hiGate     (hiGate),
    .loGate     (loGate),
    .strobe     (strobe)
  );

  hbg_gate_reg u_gates (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .hiGate (hiGate),
    .loGate (loGate)
  );

  // Independent run length of both-off cycles, observed at the outputs.
  localparam logic [DT_W-1:0] RUN_MAX = {DT_W{1'b1}};
  logic [DT_W-1:0] lowRun;
  logic [DT_W-1:0] minGap;

  assign minGap = (deadCycles == '0) ? DT_W'(1) : deadCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowRun <= RUN_MAX;
    else if (hiGate || loGate)  lowRun <= '0;
    else if (lowRun != RUN_MAX) lowRun <= lowRun + DT_W'(1);
  end

  assert_gap_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hiGate) || $rose(loGate)) |-> (lowRun >= $past(minGap)));

  assert_shutdown_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!enable || underVolt) |=> (!hiGate && !loGate));

  assert_hi_decode_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiGate) |-> $past(hiCmd && loCmdN));

  assert_lo_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loGate) |-> $past(!hiCmd && !loCmdN));

endmodule

// File: tb/halfbridge_guard_tb_top.sv
module halfbridge_guard_tb_top;

  localparam int DT_W = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            hiCmd = 1'b0;
  logic            loCmdN = 1'b1;
  logic            enable = 1'b1;
  logic            underVolt = 1'b0;
  logic [DT_W-1:0] deadCycles = 8'd3;
  logic            hiGate;
  logic            loGate;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  halfbridge_guard #(.DT_W(DT_W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .hiCmd      (hiCmd),
    .loCmdN     (loCmdN),
    .enable     (enable),
    .underVolt  (underVolt),
    .deadCycles (deadCycles),
    .hiGate     (hiGate),
    .loGate     (loGate)
  );

  // Every check also confirms that the gates are never on together (R6).
  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp || (hiGate && loGate)) begin
      fails++;
      $display("FAIL %s: {hi,lo} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waits n rising edges, then returns at the following falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setCmd(input logic h, input logic lN);
    hiCmd  = h;
    loCmdN = lN;
  endtask

  // Steps one edge, then counts the cycles with both gates off.
  task automatic countGap(output int n);
    n = 0;
    step(1);
    while (!hiGate && !loGate && n < 300) begin
      n++;
      step(1);
    end
  endtask

  function automatic int effDt(input logic [DT_W-1:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic testReset();
    rstN = 1'b0;
    setCmd(1'b1, 1'b1);
    deadCycles = 8'd5;
    step(2);
    check("R10 reset state", {hiGate, loGate}, 2'b00);
    rstN = 1'b1;
    step(1);
    check("R10 expired gap after reset", {hiGate, loGate}, 2'b10);
  endtask

  task automatic testTruth();
    deadCycles = 8'd2;
    setCmd(1'b0, 1'b1);
    step(5);
    check("R5 idle pair", {hiGate, loGate}, 2'b00);
    setCmd(1'b0, 1'b0);
    step(1);
    check("R2 low pair", {hiGate, loGate}, 2'b01);
    setCmd(1'b1, 1'b0);
    step(1);
    check("R4 conflict pair", {hiGate, loGate}, 2'b00);
    step(4);
    check("R4 conflict holds", {hiGate, loGate}, 2'b00);
    setCmd(1'b1, 1'b1);
    step(1);
    check("R3 high pair", {hiGate, loGate}, 2'b10);
  endtask

  task automatic testTied(input logic [DT_W-1:0] d);
    int n;
    deadCycles = d;
    setCmd(1'b1, 1'b1);
    step(10);
    check("R11 tied high", {hiGate, loGate}, 2'b10);
    setCmd(1'b0, 1'b0);
    countGap(n);
    checkInt("R7 gap high->low", n, effDt(d));
    check("R11 tied low", {hiGate, loGate}, 2'b01);
    step(3);
    setCmd(1'b1, 1'b1);
    countGap(n);
    checkInt("R7 gap low->high", n, effDt(d));
    check("R11 tied high again", {hiGate, loGate}, 2'b10);
  endtask

  task automatic testGaps();
    int n;
    deadCycles = 8'd4;
    setCmd(1'b0, 1'b0);
    step(10);
    setCmd(1'b0, 1'b1);
    step(1);
    check("R8 short idle off", {hiGate, loGate}, 2'b00);
    setCmd(1'b1, 1'b1);
    countGap(n);
    checkInt("R8 short gap enforced", n + 1, 4);
    setCmd(1'b0, 1'b1);
    step(8);
    setCmd(1'b0, 1'b0);
    step(1);
    check("R8 long gap direct", {hiGate, loGate}, 2'b01);
  endtask

  task automatic testEnable();
    deadCycles = 8'd3;
    setCmd(1'b1, 1'b1);
    step(8);
    enable = 1'b0;
    step(1);
    check("R1 shutdown off", {hiGate, loGate}, 2'b00);
    setCmd(1'b0, 1'b0);
    step(2);
    check("R1 shutdown ignores command", {hiGate, loGate}, 2'b00);
    setCmd(1'b1, 1'b1);
    step(4);
    enable = 1'b1;
    step(1);
    check("R1 resume after shutdown", {hiGate, loGate}, 2'b10);
  endtask

  task automatic testUv();
    int n;
    deadCycles = 8'd4;
    setCmd(1'b1, 1'b1);
    step(8);
    underVolt = 1'b1;
    step(1);
    check("R9 undervoltage off", {hiGate, loGate}, 2'b00);
    step(10);
    check("R9 undervoltage holds", {hiGate, loGate}, 2'b00);
    underVolt = 1'b0;
    countGap(n);
    checkInt("R9 full gap after clear", n, 4);
    check("R9 resumes high", {hiGate, loGate}, 2'b10);
  endtask

  initial begin
    step(1);
    testReset();
    testTruth();
    testTied(8'd3);
    testTied(8'd0);
    testTied(8'd7);
    testGaps();
    testEnable();
    testUv();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule